// File: doc/BRIEF.md
# Overcurrent Shutdown Timer

This block turns a digital overcurrent flag into a gate shutdown request for a three-phase bridge driver. The flag comes from an analog comparator that fires when the shunt voltage rises past its threshold. It reaches this block already synchronised to the clock.

A rising edge of the flag starts an off-time. The length of the off-time is a cycle count presented on an input and captured at the moment of the trigger. When the count runs out, the block looks at the flag again. If the flag is still high, the shutdown continues until the flag drops. If it is low, the shutdown ends at once.

While a shutdown is in force, the fault output is high. The brake input then decides what the gates do:
- Without brake, all six gates are turned off.
- With brake, the low-side switches are held on and the high-side switches stay off. This keeps the windings shorted instead of letting them float.

Top module: `ocp_blanker`

## Requirements
- R1: A synchronous reset returns the block to idle; in the cycle after any clock edge with `rst` high, `gates_off_o`, `bot_on_o` and `fault_o` are all 0.
- R2: While idle, a clock edge at which `cmp_i` is 1 and was 0 at the previous edge (or at which reset was just released) starts a shutdown; `fault_o` is 1 from the cycle after that edge.
- R3: The off-time is N cycles, where N is `off_cnt_i` at the triggering edge; N = 0 behaves as N = 1.
- R4: Changes of `off_cnt_i` after the triggering edge do not alter the running off-time.
- R5: Rising edges of `cmp_i` during the off-time neither restart nor extend it.
- R6: If `cmp_i` is 1 at the edge that ends the off-time, the shutdown persists and ends after the first edge at which `cmp_i` is 0; with the flag high for D sampled edges, the shutdown lasts max(N, D) cycles.
- R7: If `cmp_i` is 0 at the edge that ends the off-time, the shutdown ends right after that edge.
- R8: During a shutdown with `brake_i` = 0, `gates_off_o` = 1 and `bot_on_o` = 0.
- R9: During a shutdown with `brake_i` = 1, `bot_on_o` = 1 and `gates_off_o` = 0, while `fault_o` stays 1.
- R10: Outside a shutdown, all three outputs are 0 regardless of `brake_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Synchronised overcurrent comparator flag, 1 = overcurrent |
| brake_i | input | 1 | Brake active, 1 = windings shorted through the low side |
| off_cnt_i | input | CW | Off-time length in clock cycles |
| gates_off_o | output | 1 | Request to turn every gate off |
| bot_on_o | output | 1 | Request to hold the low-side gates on during braking |
| fault_o | output | 1 | Overcurrent shutdown in force, active high |

## Verification
The hardest case to reach is the boundary between a timed release and a held release. It occurs when the comparator drops exactly at, one edge before, or one edge after the terminal count. The bench reaches it by sweeping the off-time count against the flag's high duration, so that every ordering of the two lengths occurs, each under both brake settings. Flag pulses inside the off-time and count changes after the trigger are then applied on purpose, to show that neither one moves the release edge.

// File: rtl/ocp_blanker.sv
module ocp_blanker #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_i,
  input  logic          brake_i,
  input  logic [CW-1:0] off_cnt_i,
  output logic          gates_off_o,
  output logic          bot_on_o,
  output logic          fault_o
);
  typedef enum logic [1:0] {S_IDLE, S_TIME, S_HOLD} st_t;

  st_t           st;
  logic          cmp_q;
  logic [CW-1:0] cnt;
  logic          rise;
  logic          act;

  assign rise = cmp_i & ~cmp_q;
  assign act  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      cmp_q <= 1'b0;
    end else begin
      cmp_q <= cmp_i;
      case (st)
        S_IDLE: if (rise) begin
          st  <= S_TIME;
          cnt <= off_cnt_i;
        end
        S_TIME: begin
          if (cnt <= CW'(1)) st <= cmp_i ? S_HOLD : S_IDLE;
          else               cnt <= cnt - CW'(1);
        end
        S_HOLD: if (!cmp_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fault_o     = act;
  assign gates_off_o = act & ~brake_i;
  assign bot_on_o    = act & brake_i;
endmodule

// File: rtl/ocp_blanker_chk.sv
module ocp_blanker_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmp_i,
  input logic          brake_i,
  input logic [CW-1:0] off_cnt_i,
  input logic          gates_off_o,
  input logic          bot_on_o,
  input logic          fault_o
);
  logic          rst_q;
  logic          f_q;
  logic [CW-1:0] off_q;
  logic [CW-1:0] n_cap;
  logic [CW:0]   run;
  logic [CW:0]   n_min;

  assign n_min = (n_cap == '0) ? (CW+1)'(1) : {1'b0, n_cap};

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      f_q   <= 1'b0;
      off_q <= '0;
      n_cap <= '0;
      run   <= '0;
    end else begin
      f_q   <= fault_o;
      off_q <= off_cnt_i;
      if (fault_o && !f_q) n_cap <= off_q;
      if (!fault_o)        run <= '0;
      else if (run != '1)  run <= run + 1'b1;
    end
  end

  always @(negedge clk)
    if (rst_q === 1'b1)
      a_r1_reset_quiet: assert (!fault_o && !gates_off_o && !bot_on_o);

  a_r2_edge_trips: assert property (@(posedge clk) disable iff (rst)
    (!fault_o && cmp_i && !$past(cmp_i) && !$past(rst)) |=> fault_o);

  a_r3_min_off_time: assert property (@(posedge clk) disable iff (rst)
    (f_q && !fault_o) |-> (run >= n_min));

  a_r6_release_on_low: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_o) |-> !$past(cmp_i));

  a_r8_no_brake_all_off: assert property (@(posedge clk) disable iff (rst)
    gates_off_o |-> (fault_o && !brake_i && !bot_on_o));

  a_r9_brake_bottoms_on: assert property (@(posedge clk) disable iff (rst)
    bot_on_o |-> (fault_o && brake_i));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !fault_o |-> (!gates_off_o && !bot_on_o));
endmodule

bind ocp_blanker ocp_blanker_chk #(.CW(CW)) chk_i (.*);

// File: tb/ocp_blanker_tb_top.sv
module ocp_blanker_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_i = 1'b0;
  logic          brake_i = 1'b0;
  logic [CW-1:0] off_cnt_i = '0;
  logic          gates_off_o, bot_on_o, fault_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ocp_blanker #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .cmp_i(cmp_i), .brake_i(brake_i),
    .off_cnt_i(off_cnt_i), .gates_off_o(gates_off_o),
    .bot_on_o(bot_on_o), .fault_o(fault_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(input string tag, input logic exp, input logic brk);
    chk({tag, " fault"}, fault_o, exp);
    chk("R8 gates_off", gates_off_o, exp & ~brk);
    chk("R9 bot_on", bot_on_o, exp & brk);
    if (!exp) chk("R10 idle outputs", gates_off_o | bot_on_o, 1'b0);
  endtask

  task automatic trial(input int n, input int d, input logic brk);
    int neff = (n == 0) ? 1 : n;
    int len  = (d > neff) ? d : neff;
    string tg = (d > neff) ? "R6" : "R3/R7";
    off_cnt_i = CW'(n);
    brake_i   = brk;
    cmp_i     = 1'b1;
    for (int i = 0; i < len + 3; i++) begin
      step();
      chk_all((i == 0) ? "R2" : tg, (i < len), brk);
      cmp_i = (i + 1 < d);
    end
    step();
  endtask

  initial begin
    step();
    step();
    chk_all("R1", 1'b0, 1'b0);
    rst = 1'b0;
    step();
    chk_all("R1", 1'b0, 1'b0);

    for (int b = 0; b < 2; b++)
      for (int n = 0; n <= 6; n++)
        for (int d = 1; d <= 9; d++)
          trial(n, d, logic'(b));

    // R4: count raised after trigger, off-time stays 5
    off_cnt_i = CW'(5); brake_i = 1'b0; cmp_i = 1'b1;
    step(); chk_all("R4", 1'b1, 1'b0);
    cmp_i = 1'b0; off_cnt_i = CW'(20);
    for (int i = 1; i < 9; i++) begin
      step(); chk_all("R4", (i < 5), 1'b0);
    end

    // R5: pulses inside the off-time do not restart it
    off_cnt_i = CW'(8); cmp_i = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step();
      chk_all("R5", (i < 8), 1'b0);
      cmp_i = ((i + 1) % 4 < 2) && (i + 1 < 8);
    end

    // R9 brake toggled mid-shutdown, R1 reset mid-shutdown
    off_cnt_i = CW'(10); cmp_i = 1'b1;
    step(); chk_all("R9", 1'b1, 1'b0);
    cmp_i = 1'b0; brake_i = 1'b1;
    step(); chk_all("R9", 1'b1, 1'b1);
    rst = 1'b1;
    step(); chk_all("R1", 1'b0, 1'b1);
    rst = 1'b0; brake_i = 1'b0;
    step(); chk_all("R1", 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule